// File: doc/BRIEF.md
# Dithered PWM Channel Bank

This block is a bank of pulse-width modulators that share one prescaler and one time base. Each channel holds an 8-bit setting. The upper five bits give a coarse duty in steps of one PWM-clock period within a 32-step PWM cycle. The lower three bits give a count of cycles, out of a frame of eight PWM cycles, whose high time is stretched by one extra step. Averaged over a frame, the high time is the full 8-bit value in steps, so the block reaches 8-bit resolution with only a 5-bit counter.

A 2-bit divider selection sets the PWM clock from the system clock. Per-channel enable bits pick, for each pin, either the modulated waveform or a general-purpose output value supplied from outside. Software writes reach the block as already-decoded write strobes that share one write-data bus. A new channel setting is held back until the current frame ends, so no frame mixes two settings. A change of divider restarts the whole time base.

Top module: `dpwm_bank`

## Requirements
- R1: One PWM step lasts 2, 4, 8 or 16 system-clock cycles for divider selection 00, 01, 10 or 11 (write-data bits [1:0] with `sel_we`). A PWM cycle is 32 steps and a frame is 8 cycles.
- R2: In a cycle that is not stretched, the enabled pin is high for the first D steps and low for the rest, where D is setting bits [7:3]. D = 0 with no stretching keeps the pin low.
- R3: With N = setting bits [2:0], cycle k (k = 0..7, counted from the frame start) is stretched by one step exactly when the 3-bit reversal of k is less than N. The high time over a whole frame is therefore the 8-bit setting times the step length.
- R4: With D = 31, a stretched cycle is high for all 32 steps.
- R5: A setting written during a frame takes effect at the next frame. A write in the last system-clock cycle of a frame is taken by the frame that follows. A write in the first cycle of a frame waits for the frame after.
- R6: A divider write with a value different from the current one clears the prescaler and both counters, and every channel takes its pending setting at once. A write of the same value has no effect.
- R7: Enable bit i (write-data bit i with `en_we`) set routes channel i's waveform to `pin_out[i]`. Cleared, `pin_out[i]` follows `gpio_in[i]` in the same cycle.
- R8: Reset clears all enables, settings and counters, and selects divider 00. While reset is held and after it is released, every pin follows `gpio_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dat_we | input | NCH | Per-channel setting write strobes |
| wdata | input | 8 | Shared write data |
| en_we | input | 1 | Write strobe for the enable bits (wdata[NCH-1:0]) |
| sel_we | input | 1 | Write strobe for the divider selection (wdata[1:0]) |
| gpio_in | input | NCH | General-purpose values for pins that are not enabled |
| pin_out | output | NCH | Pin values after the per-channel mux |

## Verification
A channel write can land in the same system-clock cycle as the frame wrap, when the loaded setting is being swapped. The bench measures pin high time frame by frame from a known restart. It places a write in the last cycle of frame 0, at a point inside it, and in the first cycle of frame 1. It then judges which frame first shows the new total. A divider write of an unchanged value falls in the middle of a running cycle. It is judged by whether the frame totals keep the expected value. A restart at that point would shift the phase and change the totals.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   // Per-clock events produced by the shared time base
   typedef struct packed {
      logic tick;      // one PWM step elapses at this edge
      logic wrap;      // last step of the last cycle of a frame
      logic restart;   // divider changed: clear everything
   } tb_evt_t;

   // Step length in system clocks for a divider selection
   function automatic int unsigned step_len(input int unsigned sel);
      return 2 << sel;
   endfunction

endpackage

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler #(
   parameter  int SEL_W = 2,
   localparam int CNT_W = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] mask;

   always_comb begin
      span = (CNT_W+1)'(2) << sel;
      mask = span[CNT_W-1:0] - CNT_W'(1);
      tick = (cnt_q & mask) == mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else              cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
   parameter int CYC_W = 5,
   parameter int FRM_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   output logic [CYC_W-1:0] cyc,
   output logic [FRM_W-1:0] frm,
   output logic             wrap
);

   logic [CYC_W-1:0] cyc_q;
   logic [FRM_W-1:0] frm_q;

   assign cyc  = cyc_q;
   assign frm  = frm_q;
   assign wrap = tick && (&cyc_q) && (&frm_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         frm_q <= '0;
      end else if (restart) begin
         cyc_q <= '0;
         frm_q <= '0;
      end else if (tick) begin
         cyc_q <= cyc_q + CYC_W'(1);
         if (&cyc_q) frm_q <= frm_q + FRM_W'(1);
      end
   end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
   parameter  int CYC_W      = 5,
   parameter  int FRM_W      = 3,
   parameter  bit SPREAD_REV = 1'b1,
   localparam int DAT_W      = CYC_W + FRM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [DAT_W-1:0] wdata,
   input  logic             load,
   input  logic [CYC_W-1:0] cyc,
   input  logic [FRM_W-1:0] frm,
   output logic             pwm,
   output logic [DAT_W-1:0] act
);

   logic [DAT_W-1:0] pend_q;
   logic [DAT_W-1:0] act_q;
   logic [FRM_W-1:0] pos;
   logic             ext;
   logic [CYC_W:0]   high_len;

   // Order in which frame cycles are picked for stretching
   generate
      if (SPREAD_REV) begin : g_spread
         for (genvar j = 0; j < FRM_W; j++) begin : g_bit
            assign pos[j] = frm[FRM_W-1-j];
         end
      end else begin : g_burst
         assign pos = frm;
      end
   endgenerate

   always_comb begin
      ext      = pos < act_q[FRM_W-1:0];
      high_len = {1'b0, act_q[DAT_W-1:FRM_W]} + (CYC_W+1)'(ext);
      pwm      = {1'b0, cyc} < high_len;
   end

   assign act = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (we)   pend_q <= wdata;
         if (load) act_q  <= we ? wdata : pend_q;
      end
   end

endmodule

// File: rtl/dpwm_bank.sv
module dpwm_bank #(
   parameter  int NCH        = 5,
   parameter  int CYC_W      = 5,
   parameter  int FRM_W      = 3,
   parameter  int SEL_W      = 2,
   parameter  bit SPREAD_REV = 1'b1,
   localparam int DAT_W      = CYC_W + FRM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   dat_we,
   input  logic [DAT_W-1:0] wdata,
   input  logic             en_we,
   input  logic             sel_we,
   input  logic [NCH-1:0]   gpio_in,
   output logic [NCH-1:0]   pin_out
);

   generate
      if (NCH < 1 || NCH > DAT_W) begin : g_bad_nch
         $error("dpwm_bank: NCH must lie in 1..DAT_W");
      end
      if (SEL_W < 1 || SEL_W > 3 || SEL_W > DAT_W) begin : g_bad_sel
         $error("dpwm_bank: SEL_W must lie in 1..3");
      end
      if (CYC_W < 1 || FRM_W < 1) begin : g_bad_cnt
         $error("dpwm_bank: counter widths must be positive");
      end
   endgenerate

   dpwm_pkg::tb_evt_t    evt;
   logic [SEL_W-1:0]     sel_q;
   logic [NCH-1:0]       en_q;
   logic [NCH-1:0]       pwm;
   logic [CYC_W-1:0]     cyc;
   logic [FRM_W-1:0]     frm;
   logic                 tick;
   logic                 wrap;
   logic                 restart;
   logic                 load;
   logic [NCH*DAT_W-1:0] act_flat;

   assign restart     = sel_we && (wdata[SEL_W-1:0] != sel_q);
   assign load        = restart || wrap;
   assign evt.tick    = tick;
   assign evt.wrap    = wrap;
   assign evt.restart = restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= '0;
      end else begin
         if (restart) sel_q <= wdata[SEL_W-1:0];
         if (en_we)   en_q  <= wdata[NCH-1:0];
      end
   end

   dpwm_prescaler #(.SEL_W(SEL_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (evt.restart),
      .sel     (sel_q),
      .tick    (tick)
   );

   dpwm_timebase #(.CYC_W(CYC_W), .FRM_W(FRM_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (evt.restart),
      .tick    (evt.tick),
      .cyc     (cyc),
      .frm     (frm),
      .wrap    (wrap)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dpwm_channel #(
            .CYC_W      (CYC_W),
            .FRM_W      (FRM_W),
            .SPREAD_REV (SPREAD_REV)
         ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (dat_we[i]),
            .wdata (wdata),
            .load  (load),
            .cyc   (cyc),
            .frm   (frm),
            .pwm   (pwm[i]),
            .act   (act_flat[i*DAT_W +: DAT_W])
         );
      end
   endgenerate

   assign pin_out = (en_q & pwm) | (~en_q & gpio_in);

endmodule

// File: rtl/dpwm_bank_chk.sv
module dpwm_bank_chk #(
   parameter int NCH   = 5,
   parameter int CYC_W = 5,
   parameter int FRM_W = 3,
   parameter int DAT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_we,
   input logic [DAT_W-1:0] wdata,
   input logic [NCH-1:0]   gpio_in,
   input logic [NCH-1:0]   pin_out,
   input logic [NCH-1:0]   en_q,
   input logic             tick,
   input logic             restart,
   input logic             load,
   input logic [CYC_W-1:0] cyc,
   input logic [FRM_W-1:0] frm,
   input logic [NCH*DAT_W-1:0] act_flat
);

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1

   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && (&cyc)) && !restart) |=> $stable(frm)); // R3

   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_flat)); // R5

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cyc == '0 && frm == '0)); // R6

   AST_GPIO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> ((pin_out & ~$past(wdata[NCH-1:0])) == (gpio_in & ~$past(wdata[NCH-1:0])))); // R7

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (en_q == '0)); // R8

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_zero
         AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[i] && act_flat[i*DAT_W +: DAT_W] == '0) |-> !pin_out[i]); // R2
      end
   endgenerate

endmodule

bind dpwm_bank dpwm_bank_chk #(
   .NCH   (NCH),
   .CYC_W (CYC_W),
   .FRM_W (FRM_W),
   .DAT_W (DAT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_we    (en_we),
   .wdata    (wdata),
   .gpio_in  (gpio_in),
   .pin_out  (pin_out),
   .en_q     (en_q),
   .tick     (tick),
   .restart  (restart),
   .load     (load),
   .cyc      (cyc),
   .frm      (frm),
   .act_flat (act_flat)
);

// File: tb/dpwm_bank_bench.sv
module dpwm_bank_bench;

   localparam int NCH = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] dat_we = '0;
   logic [7:0]     wdata = '0;
   logic           en_we = 1'b0;
   logic           sel_we = 1'b0;
   logic [NCH-1:0] gpio_in = '0;
   logic [NCH-1:0] pin_out;

   int checks = 0;
   int fails  = 0;
   int hc [NCH][24];
   int ft [NCH][3];

   always #5 clk = ~clk;

   dpwm_bank u_dpwm_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .dat_we  (dat_we),
      .wdata   (wdata),
      .en_we   (en_we),
      .sel_we  (sel_we),
      .gpio_in (gpio_in),
      .pin_out (pin_out)
   );

   // {divider selection, setting, expected frame high time in system clocks}
   localparam logic [25:0] VEC [8] = '{
      {2'd0, 8'h00, 16'd0},
      {2'd0, 8'h08, 16'd16},
      {2'd0, 8'h07, 16'd14},
      {2'd0, 8'h45, 16'd138},
      {2'd1, 8'hA3, 16'd652},
      {2'd2, 8'hFF, 16'd2040},
      {2'd3, 8'h81, 16'd2064},
      {2'd0, 8'hFC, 16'd504}
   };

   task automatic chk(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic wr_dat(input int ch, input logic [7:0] v);
      @(negedge clk); dat_we = '0; dat_we[ch] = 1'b1; wdata = v;
      @(negedge clk); dat_we = '0;
   endtask

   task automatic wr_en(input logic [NCH-1:0] v);
      @(negedge clk); en_we = 1'b1; wdata = {3'b0, v};
      @(negedge clk); en_we = 1'b0;
   endtask

   task automatic wr_sel(input logic [1:0] d);
      @(negedge clk); sel_we = 1'b1; wdata = {6'b0, d};
      @(negedge clk); sel_we = 1'b0;
   endtask

   // Leaves the bench at the first system-clock slot after a restart
   task automatic restart(input logic [1:0] d);
      wr_sel(d ^ 2'b01);
      wr_sel(d);
   endtask

   // Sample all pins slot by slot; optional write (1 data, 2 divider) at slot ws
   task automatic run(input int nfr, input int step, input int kind, input int ws,
                      input int wch, input logic [7:0] wv);
      int flen;
      flen = 256 * step;
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 24; k++) hc[c][k] = 0;
         for (int f = 0; f < 3; f++) ft[c][f] = 0;
      end
      for (int s = 0; s < nfr * flen; s++) begin
         for (int c = 0; c < NCH; c++) begin
            if (pin_out[c]) begin
               hc[c][s / (32 * step)]++;
               ft[c][s / flen]++;
            end
         end
         dat_we = '0;
         sel_we = 1'b0;
         if (s == ws) begin
            wdata = wv;
            if (kind == 1) dat_we[wch] = 1'b1;
            if (kind == 2) sel_we = 1'b1;
         end
         @(negedge clk);
      end
      dat_we = '0;
      sel_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R8: reset state
      gpio_in = 5'b10110;
      repeat (3) @(negedge clk);
      #1 chk("R8", int'(pin_out), 5'b10110, "pins during reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R8", int'(pin_out), 5'b10110, "pins after reset");
      wr_dat(0, 8'hFF);
      restart(2'd0);
      repeat (3) @(negedge clk);
      chk("R8", int'(pin_out), 5'b10110, "enables cleared by reset");

      // R1: step length per divider selection, setting D=1 N=0 on channel 0
      wr_en('1);
      wr_dat(0, 8'h08);
      for (int d = 0; d < 4; d++) begin
         int step;
         step = 2 << d;
         restart(2'(d));
         repeat (step - 1) @(negedge clk);
         chk("R1", int'(pin_out[0]), 1, $sformatf("sel %0d last high slot", d));
         @(negedge clk);
         chk("R1", int'(pin_out[0]), 0, $sformatf("sel %0d first low slot", d));
         repeat (31 * step) @(negedge clk);
         chk("R1", int'(pin_out[0]), 1, $sformatf("sel %0d next cycle start", d));
      end

      // R2 R3 R4: vector table, one frame each
      for (int i = 0; i < 8; i++) begin
         logic [1:0] dv;
         logic [7:0] dat;
         int tot, step, ch, dd, nn;
         {dv, dat, tot} = {VEC[i][25:24], VEC[i][23:16], int'(VEC[i][15:0])};
         step = 2 << dv;
         ch = i % NCH;
         dd = int'(dat[7:3]);
         nn = int'(dat[2:0]);
         wr_dat(ch, dat);
         restart(dv);
         run(1, step, 0, -1, 0, 8'h00);
         for (int k = 0; k < 8; k++) begin
            logic [2:0] kb, rv;
            int ex;
            kb = 3'(k);
            rv = {kb[0], kb[1], kb[2]};
            ex = (int'(rv) < nn) ? 1 : 0;
            chk((dd == 31 && ex == 1) ? "R4" : ((ex == 1) ? "R3" : "R2"),
                hc[ch][k], (dd + ex) * step,
                $sformatf("vec %0d cycle %0d high time", i, k));
         end
         chk("R3", ft[ch][0], tot, $sformatf("vec %0d frame high time", i));
      end

      // R3: independent channels in one frame
      begin
         logic [7:0] mv [NCH];
         mv = '{8'h10, 8'h21, 8'h33, 8'hF7, 8'h00};
         for (int c = 0; c < NCH; c++) wr_dat(c, mv[c]);
         restart(2'd0);
         run(1, 2, 0, -1, 0, 8'h00);
         for (int c = 0; c < NCH; c++)
            chk("R3", ft[c][0], 2 * int'(mv[c]), $sformatf("channel %0d frame total", c));
      end

      // R5: setting update deferred to a frame boundary
      begin
         int slots [3];
         int exp1 [3];
         int exp2 [3];
         slots = '{100, 511, 512};
         exp1  = '{262, 262, 128};
         exp2  = '{262, 262, 262};
         for (int t = 0; t < 3; t++) begin
            wr_dat(1, 8'h40);
            restart(2'd0);
            run(3, 2, 1, slots[t], 1, 8'h83);
            chk("R5", ft[1][0], 128, $sformatf("write slot %0d frame 0", slots[t]));
            chk("R5", ft[1][1], exp1[t], $sformatf("write slot %0d frame 1", slots[t]));
            chk("R5", ft[1][2], exp2[t], $sformatf("write slot %0d frame 2", slots[t]));
         end
      end

      // R6: writing the current divider value leaves the phase alone
      wr_dat(0, 8'h45);
      restart(2'd0);
      run(2, 2, 2, 100, 0, 8'h00);
      chk("R6", ft[0][0], 138, "same divider write frame 0");
      chk("R6", ft[0][1], 138, "same divider write frame 1");
      chk("R6", hc[0][1], 18, "same divider write cycle 1");

      // R7: per-pin routing
      wr_en(5'b00100);
      wr_dat(2, 8'h00);
      gpio_in = 5'b11111;
      restart(2'd0);
      #1 chk("R7", int'(pin_out), 5'b11011, "only pin 2 routed");
      @(negedge clk); gpio_in = 5'b01010;
      #1 chk("R7", int'(pin_out), 5'b01010, "gpio follows same cycle");
      wr_en(5'b00000);
      gpio_in = 5'b00100;
      #1 chk("R7", int'(pin_out), 5'b00100, "pin 2 back to gpio");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule